// File: doc/BRIEF.md
# Wide Event Timer with Comparator

This block is a memory-mapped timer for a processor subsystem. A 64-bit up-counter runs from the block clock through a programmable divider. A 64-bit comparator watches the counter and raises a sticky event flag once the count has reached the programmed value. The flag drives an interrupt line through an enable gate.

Software uses a plain 32-bit register port with byte address, write strobe, write data and combinational read data. The counter and the comparator each appear as a pair of 32-bit words. To read the count safely, software reads the upper word, then the lower word, then the upper word again, and repeats until the two upper reads agree. To move the comparator without a stray event, software clears the compare enable, writes the lower word, then the upper word, and then sets the enable again. For periodic events, software sets an increment value. Each hit then pushes the comparator forward by that amount in hardware.

Top module: `wide_event_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: While the run bit (control bit 0) is 1, the counter goes up by one every P+1 clocks, where P is control bits [11:8].
- R3: While the run bit is 0, the counter holds its value.
- R4: Byte offset 0x00 holds counter bits [31:0] and offset 0x04 holds bits [63:32]. A write replaces only the addressed word and suppresses the increment in that cycle. A carry out of the lower word shows in the upper word in the same cycle as the wrap.
- R5: The event flag is status bit 0 at offset 0x0C. With compare enable (control bit 1) at 1, it is set one cycle after the counter is greater than or equal to the comparator (offsets 0x10 low, 0x14 high). Writing 1 to status bit 0 clears it. A set in the same cycle as a clear wins.
- R6: While compare enable is 0, the event flag is never set.
- R7: `irq_o` is 1 exactly when the event flag is 1 and interrupt enable (control bit 2) is 1.
- R8: With auto-increment (control bit 3) at 1, each hit adds the value at offset 0x18 to the comparator, so events recur.
- R9: With auto-increment at 0, a hit sets the flag once. No further hit occurs until a comparator word is written or compare enable is cleared.
- R10: Control reads back only bits [3:0] and [11:8], with all other bits zero. Unaligned addresses and offsets other than 0x00 to 0x18 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request, the event flag gated by interrupt enable |

## Verification
Suppose the divider phase, the arm state or the comparator is wrong. The next read of the counter or comparator word shows it, or the status word or `irq_o` changes one cycle too early, too late or not at all. This is visible within P+1 clocks of the fault. The bench steps a behavioural model in lock-step and compares the addressed read data and `irq_o` on every cycle, so a divergence is reported in the cycle it first reaches the ports. Directed scenarios then pin down the cases where a bad arm state would otherwise stay hidden: the carry between words, a comparator already below the count, a cleared flag under single-shot, and periodic rearm.

// File: rtl/wet_pkg.sv
package wet_pkg;

   typedef enum logic [2:0] {
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_CTRL,
      SEL_STAT,
      SEL_CMP_LO,
      SEL_CMP_HI,
      SEL_AINC,
      SEL_NONE
   } reg_sel_e;

   localparam int unsigned RUN_BIT   = 0;
   localparam int unsigned CMPEN_BIT = 1;
   localparam int unsigned IRQEN_BIT = 2;
   localparam int unsigned AINC_BIT  = 3;
   localparam int unsigned PRE_LSB   = 8;

   function automatic reg_sel_e decode_addr(input logic [31:0] byte_ofs);
      reg_sel_e s;
      if (byte_ofs[1:0] != 2'b00) begin
         s = SEL_NONE;
      end else begin
         case (byte_ofs[31:2])
            30'd0:   s = SEL_CNT_LO;
            30'd1:   s = SEL_CNT_HI;
            30'd2:   s = SEL_CTRL;
            30'd3:   s = SEL_STAT;
            30'd4:   s = SEL_CMP_LO;
            30'd5:   s = SEL_CMP_HI;
            30'd6:   s = SEL_AINC;
            default: s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/wet_prescale.sv
module wet_prescale #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] presc,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;

   assign tick = run && (phase_q >= presc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PRE_W'(1);
      end
   end

endmodule

// File: rtl/wet_counter.sv
module wet_counter #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32,
   localparam int NH   = CNT_W / BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [NH-1:0]    wr_half,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_wr;

   always_comb begin
      cnt_wr = cnt_q;
      for (int h = 0; h < NH; h++) begin
         if (wr_half[h]) cnt_wr[h*BUS_W +: BUS_W] = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (|wr_half) begin
         cnt_q <= cnt_wr;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt = cnt_q;

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|wr_half)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(|wr_half)) |=> $stable(cnt_q));

endmodule

// File: rtl/wet_compare.sv
module wet_compare #(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter bit GE_MATCH = 1'b1,
   localparam int NH      = CNT_W / BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cmp_en,
   input  logic             ainc_en,
   input  logic [BUS_W-1:0] ainc,
   input  logic [NH-1:0]    wr_half,
   input  logic [BUS_W-1:0] wdata,
   input  logic             clr_flag,
   output logic [CNT_W-1:0] cmp,
   output logic             flag
);
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cmp_wr;
   logic             armed_q;
   logic             flag_q;
   logic             reached;
   logic             hit;

   generate
      if (GE_MATCH) begin : g_ge
         assign reached = (cnt >= cmp_q);
      end else begin : g_eq
         assign reached = (cnt == cmp_q);
      end
   endgenerate

   assign hit = cmp_en && armed_q && reached;

   always_comb begin
      cmp_wr = cmp_q;
      for (int h = 0; h < NH; h++) begin
         if (wr_half[h]) cmp_wr[h*BUS_W +: BUS_W] = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (|wr_half) begin
         cmp_q <= cmp_wr;
      end else if (hit && ainc_en) begin
         cmp_q <= cmp_q + CNT_W'(ainc);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (!cmp_en || (|wr_half)) begin
         armed_q <= 1'b1;
      end else if (hit && !ainc_en) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (clr_flag) begin
         flag_q <= 1'b0;
      end
   end

   assign cmp  = cmp_q;
   assign flag = flag_q;

   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !flag_q) |=> !flag_q);

   assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ainc_en && !(|wr_half)) |=> (cmp_q == $past(cmp_q) + CNT_W'($past(ainc))));

   assert_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ainc_en && cmp_en && !(|wr_half)) |=> !armed_q);

endmodule

// File: rtl/wide_event_timer.sv
module wide_event_timer
   import wet_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int PRE_W    = 4,
   parameter int ADDR_W   = 8,
   parameter bit GE_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_o
);
   localparam int NH = CNT_W / BUS_W;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("CNT_W must be twice BUS_W");
      end
      if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre
         $error("PRE_W must be 1..8");
      end
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be 5..32");
      end
      if (BUS_W < PRE_LSB + PRE_W) begin : g_bad_bus
         $error("BUS_W too narrow for control");
      end
   endgenerate

   reg_sel_e         sel;
   logic             run_q, cmpen_q, irqen_q, aincen_q;
   logic [PRE_W-1:0] presc_q;
   logic [BUS_W-1:0] ainc_q;
   logic             tick;
   logic [NH-1:0]    cnt_wr, cmp_wr;
   logic [CNT_W-1:0] cnt, cmp;
   logic             flag;
   logic             clr_flag;

   assign sel      = decode_addr(32'(bus_addr));
   assign cnt_wr   = {bus_we && (sel == SEL_CNT_HI), bus_we && (sel == SEL_CNT_LO)};
   assign cmp_wr   = {bus_we && (sel == SEL_CMP_HI), bus_we && (sel == SEL_CMP_LO)};
   assign clr_flag = bus_we && (sel == SEL_STAT) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cmpen_q  <= 1'b0;
         irqen_q  <= 1'b0;
         aincen_q <= 1'b0;
         presc_q  <= '0;
      end else if (bus_we && sel == SEL_CTRL) begin
         run_q    <= bus_wdata[RUN_BIT];
         cmpen_q  <= bus_wdata[CMPEN_BIT];
         irqen_q  <= bus_wdata[IRQEN_BIT];
         aincen_q <= bus_wdata[AINC_BIT];
         presc_q  <= bus_wdata[PRE_LSB +: PRE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ainc_q <= '0;
      end else if (bus_we && sel == SEL_AINC) begin
         ainc_q <= bus_wdata;
      end
   end

   wet_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .presc (presc_q),
      .tick  (tick)
   );

   wet_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_half (cnt_wr),
      .wdata   (bus_wdata),
      .cnt     (cnt)
   );

   wet_compare #(.CNT_W(CNT_W), .BUS_W(BUS_W), .GE_MATCH(GE_MATCH)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .cmp_en   (cmpen_q),
      .ainc_en  (aincen_q),
      .ainc     (ainc_q),
      .wr_half  (cmp_wr),
      .wdata    (bus_wdata),
      .clr_flag (clr_flag),
      .cmp      (cmp),
      .flag     (flag)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
         SEL_CNT_HI: bus_rdata = cnt[CNT_W-1:BUS_W];
         SEL_CTRL: begin
            bus_rdata[RUN_BIT]           = run_q;
            bus_rdata[CMPEN_BIT]         = cmpen_q;
            bus_rdata[IRQEN_BIT]         = irqen_q;
            bus_rdata[AINC_BIT]          = aincen_q;
            bus_rdata[PRE_LSB +: PRE_W]  = presc_q;
         end
         SEL_STAT:   bus_rdata[0] = flag;
         SEL_CMP_LO: bus_rdata = cmp[BUS_W-1:0];
         SEL_CMP_HI: bus_rdata = cmp[CNT_W-1:BUS_W];
         SEL_AINC:   bus_rdata = ainc_q;
         default:    bus_rdata = '0;
      endcase
   end

   assign irq_o = flag && irqen_q;

   assert_irq_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !clr_flag && !(bus_we && sel == SEL_CTRL)) |=> (irq_o -> $rose(flag)));

endmodule

// File: tb/wide_event_timer_test.sv
module wide_event_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string tag = "R1";

   // behavioural reference state
   longint unsigned m_cnt, m_cmp;
   int unsigned     m_ainc, m_pre;
   bit m_run, m_cen, m_ien, m_aen, m_armed, m_flag;
   int unsigned m_p;

   always #5 clk = ~clk;

   wide_event_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", t, got, exp);
      end
   endtask

   function automatic logic [31:0] mread(input logic [7:0] a);
      case (a)
         8'h00: return m_cnt[31:0];
         8'h04: return m_cnt[63:32];
         8'h08: return {20'd0, 4'(m_p), 4'd0, m_aen, m_ien, m_cen, m_run};
         8'h0C: return {31'd0, m_flag};
         8'h10: return m_cmp[31:0];
         8'h14: return m_cmp[63:32];
         8'h18: return m_ainc;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_cmp = 0; m_ainc = 0; m_pre = 0; m_p = 0;
      m_run = 0; m_cen = 0; m_ien = 0; m_aen = 0; m_armed = 1; m_flag = 0;
   endtask

   // one clock: drive at the falling edge, compare, then advance model
   task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d);
      bit tk, hit, cw;
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      chk({tag, " rdata"}, bus_rdata, mread(a));
      chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_flag & m_ien});
      tk  = m_run && (m_pre >= m_p);
      hit = m_cen && m_armed && (m_cnt >= m_cmp);
      cw  = we && (a == 8'h10 || a == 8'h14);
      @(posedge clk);
      m_pre = (!m_run || tk) ? 0 : m_pre + 1;
      if (we && a == 8'h00)      m_cnt = {m_cnt[63:32], d};
      else if (we && a == 8'h04) m_cnt = {d, m_cnt[31:0]};
      else if (tk)               m_cnt = m_cnt + 1;
      if (we && a == 8'h10)      m_cmp = {m_cmp[63:32], d};
      else if (we && a == 8'h14) m_cmp = {d, m_cmp[31:0]};
      else if (hit && m_aen)     m_cmp = m_cmp + longint'(m_ainc);
      if (!m_cen || cw)          m_armed = 1;
      else if (hit && !m_aen)    m_armed = 0;
      if (hit)                                 m_flag = 1;
      else if (we && a == 8'h0C && d[0])       m_flag = 0;
      if (we && a == 8'h08) begin
         m_run = d[0]; m_cen = d[1]; m_ien = d[2]; m_aen = d[3]; m_p = d[11:8];
      end
      if (we && a == 8'h18) m_ainc = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n, input logic [7:0] a);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      tag = "R1";
      for (int a = 0; a <= 8'h18; a += 4) begin
         bus_addr = 8'(a); #1;
         chk("R1 reset read", bus_rdata, 32'd0);
      end
      chk("R1 irq", {31'd0, irq_o}, 32'd0);

      // R10: control only keeps defined bits, unused offsets read zero
      tag = "R10";
      step(1'b1, 8'h08, 32'hFFFF_FFF0);
      bus_addr = 8'h08; #1;
      chk("R10 ctrl mask", bus_rdata, 32'h0000_0F00);
      step(1'b1, 8'h08, 32'h0);
      step(1'b1, 8'h1C, 32'hDEAD_BEEF);
      step(1'b0, 8'h1C, 0); step(1'b0, 8'h02, 0); step(1'b0, 8'h40, 0);
      bus_addr = 8'h1C; #1;
      chk("R10 unused", bus_rdata, 32'd0);

      // R2: counting with prescaler 0 and 3
      tag = "R2";
      step(1'b1, 8'h08, 32'h0000_0001);
      idle(10, 8'h00);
      bus_addr = 8'h00; #1;
      chk("R2 count P=0", bus_rdata, 32'd10);
      step(1'b1, 8'h08, 32'h0000_0301);
      idle(24, 8'h00);
      step(1'b1, 8'h08, 32'h0000_0F01);
      idle(40, 8'h00);

      // R3: stopped counter holds
      tag = "R3";
      step(1'b1, 8'h08, 32'h0);
      bus_addr = 8'h00; #1;
      begin
         logic [31:0] held;
         held = bus_rdata;
         idle(8, 8'h00);
         bus_addr = 8'h00; #1;
         chk("R3 hold", bus_rdata, held);
      end

      // R4: word writes and carry into upper word
      tag = "R4";
      step(1'b1, 8'h00, 32'hFFFF_FFFD);
      step(1'b1, 8'h04, 32'h0000_0007);
      step(1'b1, 8'h08, 32'h0000_0001);
      idle(2, 8'h04);
      bus_addr = 8'h04; #1;
      chk("R4 before wrap", bus_rdata, 32'd7);
      idle(1, 8'h04);
      bus_addr = 8'h04; #1;
      chk("R4 carry", bus_rdata, 32'd8);
      step(1'b1, 8'h00, 32'd0);
      bus_addr = 8'h00; #1;
      chk("R4 write no inc", bus_rdata, 32'd0);
      step(1'b1, 8'h04, 32'd0);

      // R6: compare disabled never flags
      tag = "R6";
      step(1'b1, 8'h10, 32'd3);
      step(1'b1, 8'h14, 32'd0);
      idle(12, 8'h0C);
      bus_addr = 8'h0C; #1;
      chk("R6 no flag", bus_rdata, 32'd0);

      // R5/R7: greater-or-equal hit with counter already past comparator
      tag = "R5";
      step(1'b1, 8'h08, 32'h0000_0007);
      bus_addr = 8'h0C; #1;
      chk("R5 not yet", bus_rdata, 32'd0);
      idle(1, 8'h0C);
      bus_addr = 8'h0C; #1;
      chk("R5 ge flag", bus_rdata, 32'd1);
      tag = "R7";
      chk("R7 irq on", {31'd0, irq_o}, 32'd1);
      step(1'b1, 8'h08, 32'h0000_0003);
      chk("R7 irq gated", {31'd0, irq_o}, 32'd0);

      // R9: single-shot does not fire again after clear
      tag = "R9";
      step(1'b1, 8'h0C, 32'd1);
      idle(15, 8'h0C);
      bus_addr = 8'h0C; #1;
      chk("R9 no repeat", bus_rdata, 32'd0);
      step(1'b1, 8'h08, 32'h0000_0001);
      step(1'b1, 8'h08, 32'h0000_0007);
      idle(2, 8'h0C);
      bus_addr = 8'h0C; #1;
      chk("R9 rearm by toggle", bus_rdata, 32'd1);
      step(1'b1, 8'h0C, 32'd1);
      step(1'b1, 8'h10, 32'd200);
      idle(220, 8'h0C);

      // R8: periodic rearm by auto-increment
      tag = "R8";
      step(1'b1, 8'h08, 32'h0000_0000);
      step(1'b1, 8'h0C, 32'd1);
      step(1'b1, 8'h00, 32'd0);
      step(1'b1, 8'h10, 32'd10);
      step(1'b1, 8'h18, 32'd7);
      step(1'b1, 8'h08, 32'h0000_000F);
      for (int k = 0; k < 6; k++) begin
         idle(6, 8'h10);
         step(1'b1, 8'h0C, 32'd1);
      end
      bus_addr = 8'h10; #1;
      chk("R8 cmp advanced", {31'd0, bus_rdata > 32'd40}, 32'd1);

      // R5: set wins over clear in the same cycle
      tag = "R5";
      step(1'b1, 8'h08, 32'h0000_0003);
      step(1'b1, 8'h10, 32'hFFFF_FFFF);
      step(1'b1, 8'h0C, 32'd1);
      step(1'b1, 8'h10, 32'd0);
      step(1'b1, 8'h0C, 32'd1);
      bus_addr = 8'h0C; #1;
      chk("R5 set beats clear", bus_rdata, 32'd1);
      idle(4, 8'h14);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule